// File: doc/BRIEF.md
# Trigger Type Encoder with Per-Bit Prescale

This block sits between a global trigger processor and the trigger distribution links. Every clock it takes a 32-bit pattern of trigger conditions. Each condition bit has its own prescaler, which thins the rising edges of that bit. The surviving bits are reduced to a single 8-bit trigger type: the lowest-numbered surviving bit indexes a programmable table of 32 types. The result goes out as a 16-bit distribution word that carries the type, a trigger-valid flag and a sync flag.

A busy input from the readout side vetoes triggers that would otherwise go out, and a saturating counter tallies them. Sync requests never collide with triggers. A request that meets a trigger is held and sent in the first cycle that has no trigger. A free-running timestamp counts clock cycles (4 ns per tick at 250 MHz), and it is captured whenever a trigger word is sent. Prescale values and table entries are loaded through a narrow write port.

Top module: `trig_type_encoder`

## Requirements
- R1: A bit with prescale value N > 0 passes on every Nth rising edge of that bit. Edges are counted since reset or since the last write of that bit's prescale. A bit held high counts as one edge.
- R2: A bit whose prescale value is 0 never produces a trigger, however often it toggles.
- R3: Two clock edges after a rising edge is sampled, the word carries the trigger type in bits 7:0 and a 1 in bit 8. The type is the table entry of the lowest-numbered bit that passed its prescaler in that cycle.
- R4: Bits 15:10 of the word are always 0. The word is all zeros in a cycle with neither trigger nor sync. Each accepted trigger gives a valid word for exactly one cycle.
- R5: A trigger that reaches selection while busy_i is high is not sent. Instead the veto counter rises by one, and it saturates at its maximum. The counter changes in no other case.
- R6: A sync_req_i pulse yields a word with bit 9 set and bits 8:0 zero at the next edge when no trigger goes out at that edge. Otherwise it is held pending and sent at the first edge without a trigger. Requests that arrive while one is pending merge into it. Bits 8 and 9 are never set together.
- R7: ts_o advances by one every clock. trig_ts_o takes the value of ts_o at the edge that sends a trigger word. The difference between two captured stamps therefore equals the number of cycles between the two trigger words.
- R8: During and after reset the word, ts_o and the veto counter are 0. Every prescale value is 0, so every bit is disabled. Table entry i holds the type value i.
- R9: When cfg_we_i is high, cfg_sel_i = 0 writes cfg_data_i into the prescale of bit cfg_idx_i and restarts that bit's edge count. cfg_sel_i = 1 writes table entry cfg_idx_i. Either write takes effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pattern_i | input | 32 | Trigger condition pattern |
| busy_i | input | 1 | Readout busy, vetoes triggers |
| sync_req_i | input | 1 | Request to send a sync word |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects the prescale value, 1 selects the type table |
| cfg_idx_i | input | 5 | Bit or table index to write |
| cfg_data_i | input | 16 | Write data (prescale in low PS_W bits, type in low 8 bits) |
| link_word_o | output | 16 | Distribution word |
| veto_cnt_o | output | 32 | Saturating count of vetoed triggers |
| ts_o | output | 48 | Free-running timestamp |
| trig_ts_o | output | 48 | Timestamp captured with the last trigger word |

## Verification
A rising edge sampled at one edge sets the prescaler output at that edge, and the trigger word follows at the next edge. The busy input is judged at that second edge, where the veto count also moves. A sync request appears one edge after it is sampled, unless a trigger takes that slot. The bench keeps an edge-by-edge reference model built from these latencies, so every output is predicted for the edge that is coming. Inputs are driven and outputs compared on the falling edge. The bench sweeps every bit under several prescale values, then random multi-bit patterns with busy and sync requests, and runs with a narrow veto counter so that saturation is reached.

// File: rtl/trig_enc_pkg.sv
package trig_enc_pkg;
  typedef enum logic {
    CFG_PRESCALE = 1'b0,
    CFG_TYPE     = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/trig_prescale_bit.sv
module trig_prescale_bit #(
  parameter int PS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lvl_i,
  input  logic            wr_i,
  input  logic [PS_W-1:0] wr_val_i,
  output logic            pass_o
);
  logic            lvl_q;
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] cnt_q;
  logic            pass_q;
  logic            rise;

  assign rise = lvl_i & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      ps_q   <= '0;
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      if (wr_i) begin
        ps_q   <= wr_val_i;
        cnt_q  <= '0;
        pass_q <= 1'b0;
      end else if (rise && ps_q != '0) begin
        if (cnt_q == ps_q - PS_W'(1)) begin
          cnt_q  <= '0;
          pass_q <= 1'b1;
        end else begin
          cnt_q  <= cnt_q + PS_W'(1);
          pass_q <= 1'b0;
        end
      end else begin
        pass_q <= 1'b0;
      end
    end
  end

  assign pass_o = pass_q;

  p_disabled_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_q == '0) |=> !pass_q);

  p_cnt_below_limit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_q != '0) |-> (cnt_q < ps_q));

  p_pass_needs_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_q |-> ($past(lvl_i) && !$past(lvl_q)));
endmodule

// File: rtl/trig_type_sel.sv
module trig_type_sel #(
  parameter int PAT_W  = 32,
  parameter int TYPE_W = 8,
  parameter int IDX_W  = $clog2(PAT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAT_W-1:0]  pass_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TYPE_W-1:0] wr_type_i,
  output logic              hit_o,
  output logic [TYPE_W-1:0] type_o
);
  logic [TYPE_W-1:0] lut_q [PAT_W];
  logic [IDX_W-1:0]  sel_idx;
  logic [PAT_W-1:0]  below_mask;

  for (genvar g = 0; g < PAT_W; g++) begin : g_lut
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lut_q[g] <= TYPE_W'(g);
      end else if (wr_i && wr_idx_i == IDX_W'(g)) begin
        lut_q[g] <= wr_type_i;
      end
    end
  end

  // lowest-numbered set bit wins
  always_comb begin
    sel_idx = '0;
    for (int i = PAT_W - 1; i >= 0; i--) begin
      if (pass_i[i]) sel_idx = IDX_W'(i);
    end
  end

  assign hit_o      = |pass_i;
  assign type_o     = lut_q[sel_idx];
  assign below_mask = (PAT_W'(1) << sel_idx) - PAT_W'(1);

  p_lowest_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (pass_i[sel_idx] && ((pass_i & below_mask) == '0)));
endmodule

// File: rtl/trig_word_out.sv
module trig_word_out #(
  parameter int TYPE_W = 8,
  parameter int WORD_W = 16,
  parameter int VETO_W = 32,
  parameter int TS_W   = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              busy_i,
  input  logic              sync_req_i,
  output logic [WORD_W-1:0] word_o,
  output logic [VETO_W-1:0] veto_cnt_o,
  output logic [TS_W-1:0]   ts_o,
  output logic [TS_W-1:0]   trig_ts_o
);
  localparam int VALID_BIT = TYPE_W;
  localparam int SYNC_BIT  = TYPE_W + 1;
  localparam logic [VETO_W-1:0] VETO_MAX = '1;

  logic [WORD_W-1:0] word_q;
  logic [VETO_W-1:0] veto_q;
  logic [TS_W-1:0]   ts_q;
  logic [TS_W-1:0]   trig_ts_q;
  logic              pend_q;
  logic              fire;
  logic              vetoed;
  logic              send_sync;

  assign fire      = hit_i & ~busy_i;
  assign vetoed    = hit_i & busy_i;
  assign send_sync = ~fire & (pend_q | sync_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q    <= '0;
      veto_q    <= '0;
      ts_q      <= '0;
      trig_ts_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      ts_q   <= ts_q + TS_W'(1);
      word_q <= '0;
      if (fire) begin
        word_q[TYPE_W-1:0] <= type_i;
        word_q[VALID_BIT]  <= 1'b1;
        trig_ts_q          <= ts_q;
      end else if (send_sync) begin
        word_q[SYNC_BIT] <= 1'b1;
      end
      // a pending sync survives only behind a trigger
      pend_q <= fire & (pend_q | sync_req_i);
      if (vetoed && veto_q != VETO_MAX) veto_q <= veto_q + VETO_W'(1);
    end
  end

  assign word_o     = word_q;
  assign veto_cnt_o = veto_q;
  assign ts_o       = ts_q;
  assign trig_ts_o  = trig_ts_q;

  p_busy_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && busy_i) |=> !word_o[VALID_BIT]);

  p_veto_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && busy_i && veto_cnt_o != VETO_MAX) |=> (veto_cnt_o == $past(veto_cnt_o) + VETO_W'(1)));

  p_veto_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_i && busy_i) |=> $stable(veto_cnt_o));

  p_sync_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_o[VALID_BIT] && word_o[SYNC_BIT]));

  p_pend_served_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !hit_i) |=> word_o[SYNC_BIT]);

  p_trigger_served_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !busy_i) |=> (word_o[VALID_BIT] && word_o[TYPE_W-1:0] == $past(type_i)));

  p_ts_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ts_o == $past(ts_o) + TS_W'(1)));
endmodule

// File: rtl/trig_type_encoder.sv
module trig_type_encoder #(
  parameter int PAT_W  = 32,
  parameter int TYPE_W = 8,
  parameter int PS_W   = 16,
  parameter int WORD_W = 16,
  parameter int VETO_W = 32,
  parameter int TS_W   = 48,
  localparam int IDX_W = $clog2(PAT_W),
  localparam int CFG_W = (PS_W > TYPE_W) ? PS_W : TYPE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAT_W-1:0]  pattern_i,
  input  logic              busy_i,
  input  logic              sync_req_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  output logic [WORD_W-1:0] link_word_o,
  output logic [VETO_W-1:0] veto_cnt_o,
  output logic [TS_W-1:0]   ts_o,
  output logic [TS_W-1:0]   trig_ts_o
);
  import trig_enc_pkg::*;

  logic [PAT_W-1:0]  pass;
  logic              ps_wr;
  logic              lut_wr;
  logic              hit;
  logic [TYPE_W-1:0] sel_type;

  assign ps_wr  = cfg_we_i && (cfg_sel_e'(cfg_sel_i) == CFG_PRESCALE);
  assign lut_wr = cfg_we_i && (cfg_sel_e'(cfg_sel_i) == CFG_TYPE);

  for (genvar g = 0; g < PAT_W; g++) begin : g_bit
    trig_prescale_bit #(.PS_W(PS_W)) u_ps (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lvl_i   (pattern_i[g]),
      .wr_i    (ps_wr && cfg_idx_i == IDX_W'(g)),
      .wr_val_i(cfg_data_i[PS_W-1:0]),
      .pass_o  (pass[g])
    );
  end

  trig_type_sel #(.PAT_W(PAT_W), .TYPE_W(TYPE_W), .IDX_W(IDX_W)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pass_i   (pass),
    .wr_i     (lut_wr),
    .wr_idx_i (cfg_idx_i),
    .wr_type_i(cfg_data_i[TYPE_W-1:0]),
    .hit_o    (hit),
    .type_o   (sel_type)
  );

  trig_word_out #(.TYPE_W(TYPE_W), .WORD_W(WORD_W), .VETO_W(VETO_W), .TS_W(TS_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .type_i    (sel_type),
    .busy_i    (busy_i),
    .sync_req_i(sync_req_i),
    .word_o    (link_word_o),
    .veto_cnt_o(veto_cnt_o),
    .ts_o      (ts_o),
    .trig_ts_o (trig_ts_o)
  );

  p_upper_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_word_o[WORD_W-1:TYPE_W+2] == '0);

  p_no_direct_path_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_word_o[TYPE_W] |-> $past(hit));
endmodule

// File: tb/trig_type_encoder_bench.sv
module trig_type_encoder_bench;
  localparam int PAT_W = 32;
  localparam int PS_W  = 4;
  localparam int VW    = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pattern = '0;
  logic        busy = 1'b0, sreq = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [7:0]  cfg_data = '0;
  logic [15:0] word;
  logic [VW-1:0] veto;
  logic [47:0] ts, trig_ts;

  int checks = 0, errors = 0;
  string cur_tag = "R8";

  // reference state
  logic [3:0]  m_ps  [PAT_W];
  logic [3:0]  m_cnt [PAT_W];
  logic [7:0]  m_lut [PAT_W];
  logic [31:0] m_prev = '0, m_pass = '0;
  logic        m_pend = 1'b0;
  logic [VW-1:0] m_veto = '0;
  logic [15:0] exp_word;
  longint      cyc = 0, last_cyc = -1;
  logic [47:0] last_ts = '0;

  always #2 clk = ~clk;

  trig_type_encoder #(.PS_W(PS_W), .VETO_W(VW)) u_trig_type_encoder (
    .clk_i(clk), .rst_ni(rst_ni), .pattern_i(pattern), .busy_i(busy),
    .sync_req_i(sreq), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data), .link_word_o(word),
    .veto_cnt_o(veto), .ts_o(ts), .trig_ts_o(trig_ts));

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] pat, input logic b, input logic s,
                      input logic we = 0, input logic sel = 0,
                      input logic [4:0] idx = 0, input logic [7:0] data = 0);
    logic fire;
    int   seln;
    logic [31:0] npass;
    string t;
    pattern = pat; busy = b; sreq = s;
    cfg_we = we; cfg_sel = sel; cfg_idx = idx; cfg_data = data;
    fire = (m_pass != 0) && !b;
    seln = 0;
    for (int i = PAT_W - 1; i >= 0; i--) if (m_pass[i]) seln = i;
    if (fire) exp_word = {7'b0, 1'b1, m_lut[seln]};
    else if (m_pend || s) exp_word = 16'h0200;
    else exp_word = '0;
    if ((m_pass != 0) && b && m_veto != {VW{1'b1}}) m_veto = m_veto + 1'b1;
    m_pend = fire && (m_pend || s);
    for (int i = 0; i < PAT_W; i++) begin
      npass[i] = 1'b0;
      if (we && !sel && idx == 5'(i)) begin
        m_ps[i] = data[3:0]; m_cnt[i] = '0;
      end else if (pat[i] && !m_prev[i] && m_ps[i] != 0) begin
        if (m_cnt[i] == m_ps[i] - 4'd1) begin
          m_cnt[i] = '0; npass[i] = 1'b1;
        end else m_cnt[i] = m_cnt[i] + 4'd1;
      end
    end
    if (we && sel) m_lut[idx] = data;
    m_pass = npass;
    m_prev = pat;
    @(negedge clk);
    cyc++;
    t = (exp_word[9] || word[9]) ? "R6" : cur_tag;
    if (word[15:10] != 0) t = "R4";
    check(word === exp_word, t, "link word", word, exp_word);
    check(veto === m_veto, "R5", "veto count", veto, m_veto);
    if (word[8]) begin
      if (last_cyc >= 0)
        check(trig_ts - last_ts == 48'(cyc - last_cyc), "R7", "stamp delta",
              trig_ts - last_ts, cyc - last_cyc);
      last_ts = trig_ts; last_cyc = cyc;
    end
  endtask

  task automatic pulse(input logic [31:0] pat, input int n);
    for (int k = 0; k < n; k++) begin
      step(pat, 0, 0);
      step('0, 0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'h1;
    for (int i = 0; i < PAT_W; i++) begin
      m_ps[i] = '0; m_cnt[i] = '0; m_lut[i] = 8'(i);
    end
    repeat (3) @(negedge clk);
    check(word === 16'h0 && veto === '0 && ts === '0, "R8", "reset outputs",
          {word, 4'(veto)}, 0);
    rst_ni = 1'b1;

    // R8/R2: all bits disabled after reset, default table
    cur_tag = "R2";
    pulse(32'hFFFF_FFFF, 3);
    cur_tag = "R8";
    step('0, 0, 0, 1, 0, 5'd3, 8'd1);
    pulse(32'h0000_0008, 2);
    pulse(32'h0000_0088, 2);

    // R1/R2 sweep over each bit with assorted prescales
    for (int i = 0; i < PAT_W; i++) step('0, 0, 0, 1, 0, 5'(i), 8'(i % 5));
    for (int i = 0; i < PAT_W; i++) step('0, 0, 0, 1, 1, 5'(i), 8'((i * 37 + 5) & 8'hFF));
    for (int i = 0; i < PAT_W; i++) begin
      cur_tag = (i % 5 == 0) ? "R2" : "R1";
      pulse(32'(1) << i, 6);
      step(32'(1) << i, 0, 0); step(32'(1) << i, 0, 0); step(32'(1) << i, 0, 0);
      step('0, 0, 0);
    end

    // R9: prescale rewrite restarts count, table rewrite
    cur_tag = "R9";
    step('0, 0, 0, 1, 0, 5'd1, 8'd3);
    pulse(32'h2, 2);
    step('0, 0, 0, 1, 0, 5'd1, 8'd2);
    pulse(32'h2, 2);
    step('0, 0, 0, 1, 1, 5'd1, 8'hC3);
    pulse(32'h2, 2);

    // R3: random multi-bit patterns
    cur_tag = "R3";
    for (int i = 0; i < PAT_W; i++) step('0, 0, 0, 1, 0, 5'(i), 8'(i % 3 + 1));
    for (int k = 0; k < 1500; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr & {lfsr[7:0], lfsr[31:8]}, 0, 0);
    end

    // R5: busy vetoes, counter saturates
    cur_tag = "R5";
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr, lfsr[3], 0);
    end

    // R6: sync requests against triggers
    cur_tag = "R6";
    step('0, 0, 0, 1, 0, 5'd0, 8'd1);
    step(32'h1, 0, 0);
    step('0, 0, 1);
    step('0, 0, 1);
    step('0, 0, 0);
    for (int k = 0; k < 800; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr & {lfsr[15:0], lfsr[31:16]}, lfsr[5] & lfsr[9], lfsr[2] & lfsr[11]);
    end
    cur_tag = "R7";
    pulse(32'h1, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule